// File: doc/BRIEF.md
# Programmable Indirect Memory Access Port

This block sits beside a small processor and gives it five indirect data channels into three memories: an external DRAM, an internal instruction RAM and a paged ROM. Every channel owns two 32-bit descriptors, one used for reads and one for writes. The upper half of a descriptor is a 16-bit word address. The lower half is a 16-bit mode that selects the target memory, the address step and the write behaviour. After each data access the address moves on by the step, so the processor can stream through memory with one register access per word.

Descriptors are never written directly. The processor first loads one shared staging register in two halves, address and then mode. It then makes a single dummy access to the chosen channel. A read stores the staged value in that channel's read descriptor, and a write stores it in the write descriptor. A channel only reaches memory when it is the dedicated memory channel or when the 2-bit routing input is nonzero. In every other case it behaves as a plain 16-bit holding register.

Read data is returned one cycle after the access. The memories are simple synchronous ports outside the block.

Top module: `pmx_port`

## Requirements
- R1: The staging register alternates between two phases. In the first phase, a write loads the upper (address) half and enters the second phase. In the second phase, a write loads the lower (mode) half, leaves the second phase and arms the register. A read returns the upper half and advances the phase in the same way, but loads nothing. Accesses to the staging register create no memory traffic.
- R2: While the staging register is armed, the next channel access copies the staged 32-bit value into that channel's read descriptor (for a read) or write descriptor (for a write). That access disarms the register, makes no memory traffic and returns zero. Every channel access also clears the second-phase state.
- R3: A channel access that does not bind reaches memory when the channel number is 4 or `mem_route` is nonzero. Otherwise a write stores into the channel's holding register and a read returns that register. At most one memory port is active in any cycle.
- R4: The step is set by mode bits 13:11. Codes 0 to 7 map to steps 0, 1, 2, 4, 8, 16, 32 and 128. Mode bit 15 set makes the step negative, and addresses wrap modulo 2^16.
- R5: A write with (mode & 0x43FF) == 0x0018 writes the DRAM word at the descriptor address. The descriptor address then advances by the step.
- R6: A read with (mode & 0x47FF) == 0x0018, and which is not a ROM read, returns the DRAM word at the descriptor address. The descriptor address then advances by the step.
- R7: In a DRAM or cell-step write with mode bit 10 set, each 4-bit nibble of the stored word is replaced only when the incoming nibble is nonzero. This is driven as nibble enables on `dram_nmask`, where bit i covers data bits 4i+3:4i.
- R8: A write with (mode & 0xFBFF) == 0x4018 is a cell-step DRAM write. Afterwards the address advances by 31 if it was odd and by 1 if it was even.
- R9: A write with (mode & 0x47FF) == 0x001C, and which is neither of the DRAM write kinds, stores into instruction RAM at address bits 9:0. The address then advances by the step. If address bits 15:10 differ from 100000b, the write still happens and `acc_err` pulses.
- R10: A read with (mode & 0xFFF0) == 0x0800 fetches the ROM word at {mode[3:0], address}. The 32-bit descriptor then increases by 0x10000, plus 1 more when the address was 0xFFFF, so the read carries into the next ROM page.
- R11: After every routed data access, the staging register is reloaded with the channel descriptor as updated by that access.
- R12: A routed access whose mode matches no kind makes no memory traffic and leaves the descriptor unchanged. A read returns zero. In both cases `acc_err` is high for the one cycle after the access.
- R13: `acc_rvalid` is high exactly in the cycle after each read access, and `acc_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_prog | input | 1 | 1 = staging register access, 0 = channel access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_chan | input | 3 | Channel number 0..4 |
| acc_wdata | input | 16 | Write data |
| mem_route | input | 2 | Routing field; nonzero sends every channel to memory |
| acc_rvalid | output | 1 | Read data valid (cycle after a read) |
| acc_rdata | output | 16 | Read data |
| acc_err | output | 1 | One-cycle pulse for an unrecognized mode or a bad instruction-RAM address |
| dram_req | output | 1 | DRAM access this cycle |
| dram_we | output | 1 | DRAM write |
| dram_addr | output | 16 | DRAM word address |
| dram_wdata | output | 16 | DRAM write data |
| dram_nmask | output | 4 | DRAM nibble write enables |
| dram_rdata | input | 16 | DRAM read data, one cycle after the request |
| iram_we | output | 1 | Instruction RAM write |
| iram_addr | output | 10 | Instruction RAM word address |
| iram_wdata | output | 16 | Instruction RAM write data |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 20 | ROM word address {page, address} |
| rom_rdata | input | 16 | ROM read data, one cycle after the request |

## Verification
The bound assertions check the cycle-level rules on every cycle:
- the one-cycle read return;
- that binding and staging accesses never touch a memory port;
- that the register disarms after a bind;
- that only one memory port is active at a time;
- that error pulses only follow channel accesses.

The meaning of the modes can only be shown by the bench scenarios, because they compare memory contents and returned words with a reference model. This covers the step encoding, negative steps, nibble-merging writes, cell stepping, ROM page carry and the staging reload.

// File: rtl/pmx_pkg.sv
// Package pmx_pkg
// Purpose : shared widths and enumerations for the indirect memory access port.
// Assumes : 16-bit data words and 32-bit descriptors {address, mode}.
package pmx_pkg;
    localparam int WORD_W = 16;
    localparam int CFG_W  = 2 * WORD_W;
    localparam int NIB_N  = WORD_W / 4;

    typedef enum logic [2:0] {
        K_BAD  = 3'd0,
        K_DRAM = 3'd1,
        K_CELL = 3'd2,
        K_IRAM = 3'd3,
        K_ROM  = 3'd4
    } acc_kind_t;

    typedef enum logic [1:0] {
        RS_REG  = 2'd0,
        RS_DRAM = 2'd1,
        RS_ROM  = 2'd2
    } rsrc_t;
endpackage

// File: rtl/pmx_mode_dec.sv
// Module pmx_mode_dec
// Purpose : classifies a descriptor's mode for a read or a write and computes the
//           descriptor value after the access (address stepping).
// Assumes : purely combinational; descriptor is {address[31:16], mode[15:0]}.
module pmx_mode_dec
    import pmx_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             is_wr,
    output acc_kind_t        kind,
    output logic             ovw,
    output logic             iram_bad,
    output logic [CFG_W-1:0] cfg_next
);
    logic [WORD_W-1:0] mode;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] mag;
    logic [WORD_W-1:0] lin_addr;
    logic [WORD_W-1:0] cell_addr;
    logic [2:0]        sidx;

    assign mode = cfg[WORD_W-1:0];
    assign addr = cfg[CFG_W-1:WORD_W];

    // Step magnitude from the nonlinear 3-bit code, then signed stepping.
    always_comb begin
        sidx = mode[13:11];
        case (sidx)
            3'd0:    mag = '0;
            3'd7:    mag = WORD_W'(128);
            default: mag = WORD_W'(1) << (sidx - 3'd1);
        endcase
        lin_addr  = mode[15] ? (addr - mag) : (addr + mag);
        cell_addr = addr + (addr[0] ? WORD_W'(31) : WORD_W'(1));
    end

    // Access kind, in decode priority order, per direction.
    always_comb begin
        kind = K_BAD;
        if (is_wr) begin
            if ((mode & 16'h43FF) == 16'h0018)      kind = K_DRAM;
            else if ((mode & 16'hFBFF) == 16'h4018) kind = K_CELL;
            else if ((mode & 16'h47FF) == 16'h001C) kind = K_IRAM;
        end else begin
            if ((mode & 16'hFFF0) == 16'h0800)      kind = K_ROM;
            else if ((mode & 16'h47FF) == 16'h0018) kind = K_DRAM;
        end
    end

    assign ovw      = mode[10];
    assign iram_bad = (addr[15:10] != 6'b100000);

    // Descriptor value after the access.
    always_comb begin
        case (kind)
            K_DRAM, K_IRAM: cfg_next = {lin_addr, mode};
            K_CELL:         cfg_next = {cell_addr, mode};
            K_ROM:          cfg_next = cfg + CFG_W'(32'h0001_0000)
                                           + CFG_W'(addr == 16'hFFFF);
            default:        cfg_next = cfg;
        endcase
    end
endmodule

// File: rtl/pmx_prog_reg.sv
// Module pmx_prog_reg
// Purpose : shared staging register with its two-phase load sequence and armed flag.
// Assumes : at most one access per cycle; a channel access clears the second phase,
//           disarms, and optionally reloads the register with an updated descriptor.
module pmx_prog_reg
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_acc,
    input  logic              prog_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              chan_acc,
    input  logic              reload_en,
    input  logic [CFG_W-1:0]  reload_val,
    output logic [CFG_W-1:0]  prog_word,
    output logic              have_addr,
    output logic              armed
);
    // Phase tracking and loading of the staging word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_word <= '0;
            have_addr <= 1'b0;
            armed     <= 1'b0;
        end else if (prog_acc) begin
            if (have_addr) begin
                if (prog_wr) prog_word[WORD_W-1:0] <= wdata;
                have_addr <= 1'b0;
                armed     <= 1'b1;
            end else begin
                if (prog_wr) prog_word[CFG_W-1:WORD_W] <= wdata;
                have_addr <= 1'b1;
            end
        end else if (chan_acc) begin
            have_addr <= 1'b0;
            armed     <= 1'b0;
            if (reload_en) prog_word <= reload_val;
        end
    end
endmodule

// File: rtl/pmx_chan_bank.sv
// Module pmx_chan_bank
// Purpose : per-channel read/write descriptors and holding registers, with a
//           selected-channel read mux.
// Assumes : one update per cycle, addressed by sel; out-of-range sel reads zero.
module pmx_chan_bank
    import pmx_pkg::*;
#(
    parameter int N_CHAN = 5,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   sel,
    input  logic              cfg_we,
    input  logic              cfg_slot_wr,
    input  logic [CFG_W-1:0]  cfg_wval,
    input  logic              hold_we,
    input  logic [WORD_W-1:0] hold_wval,
    output logic [CFG_W-1:0]  rd_cfg,
    output logic [CFG_W-1:0]  wr_cfg,
    output logic [WORD_W-1:0] hold_q
);
    logic [CFG_W-1:0]  rd_slot [N_CHAN];
    logic [CFG_W-1:0]  wr_slot [N_CHAN];
    logic [WORD_W-1:0] hold_r  [N_CHAN];

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic hit;
        assign hit = (sel == CH_W'(g));
        // Storage for channel g: two descriptors and one holding word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_slot[g] <= '0;
                wr_slot[g] <= '0;
                hold_r[g]  <= '0;
            end else begin
                if (hit && cfg_we && !cfg_slot_wr) rd_slot[g] <= cfg_wval;
                if (hit && cfg_we &&  cfg_slot_wr) wr_slot[g] <= cfg_wval;
                if (hit && hold_we)                hold_r[g]  <= hold_wval;
            end
        end
    end

    // Selected-channel read mux.
    always_comb begin
        rd_cfg = '0;
        wr_cfg = '0;
        hold_q = '0;
        for (int i = 0; i < N_CHAN; i++) begin
            if (sel == CH_W'(i)) begin
                rd_cfg = rd_slot[i];
                wr_cfg = wr_slot[i];
                hold_q = hold_r[i];
            end
        end
    end
endmodule

// File: rtl/pmx_port.sv
// Module pmx_port
// Purpose : top of the indirect memory access port. Routes each access to the
//           staging register, a descriptor bind, a holding register or a memory port,
//           and returns read data one cycle later.
// Assumes : memories answer reads one cycle after the request; one access per cycle.
module pmx_port
    import pmx_pkg::*;
#(
    parameter int N_CHAN   = 5,
    parameter int MEM_CHAN = 4,
    parameter int IRAM_AW  = 10,
    parameter int ROM_PW   = 4,
    localparam int CH_W    = $clog2(N_CHAN),
    localparam int ROM_AW  = ROM_PW + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_prog,
    input  logic              acc_write,
    input  logic [CH_W-1:0]   acc_chan,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [1:0]        mem_route,
    output logic              acc_rvalid,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic              dram_req,
    output logic              dram_we,
    output logic [WORD_W-1:0] dram_addr,
    output logic [WORD_W-1:0] dram_wdata,
    output logic [NIB_N-1:0]  dram_nmask,
    input  logic [WORD_W-1:0] dram_rdata,
    output logic              iram_we,
    output logic [IRAM_AW-1:0] iram_addr,
    output logic [WORD_W-1:0] iram_wdata,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_rdata
);
    logic              prog_acc, chan_acc, bind_acc, routed, hold_path;
    logic [CFG_W-1:0]  prog_word, rd_cfg, wr_cfg, cfg_use, cfg_next;
    logic              have_addr, armed;
    logic [WORD_W-1:0] hold_q;
    acc_kind_t         kind;
    logic              ovw, iram_bad;
    logic              err_d;
    logic [NIB_N-1:0]  nz_nib;
    logic [WORD_W-1:0] rdata_q;
    rsrc_t             rsrc_q;

    // Access classification.
    assign prog_acc  = acc_valid &&  acc_prog;
    assign chan_acc  = acc_valid && !acc_prog;
    assign bind_acc  = chan_acc && armed;
    assign routed    = chan_acc && !armed &&
                       ((acc_chan == CH_W'(MEM_CHAN)) || (mem_route != 2'b00));
    assign hold_path = chan_acc && !armed && !routed;
    assign cfg_use   = acc_write ? wr_cfg : rd_cfg;

    pmx_prog_reg u_prog (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_acc   (prog_acc),
        .prog_wr    (acc_write),
        .wdata      (acc_wdata),
        .chan_acc   (chan_acc),
        .reload_en  (routed),
        .reload_val (cfg_next),
        .prog_word  (prog_word),
        .have_addr  (have_addr),
        .armed      (armed)
    );

    pmx_chan_bank #(.N_CHAN(N_CHAN), .CH_W(CH_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (acc_chan),
        .cfg_we      (bind_acc || (routed && kind != K_BAD)),
        .cfg_slot_wr (acc_write),
        .cfg_wval    (bind_acc ? prog_word : cfg_next),
        .hold_we     (hold_path && acc_write),
        .hold_wval   (acc_wdata),
        .rd_cfg      (rd_cfg),
        .wr_cfg      (wr_cfg),
        .hold_q      (hold_q)
    );

    pmx_mode_dec u_dec (
        .cfg      (cfg_use),
        .is_wr    (acc_write),
        .kind     (kind),
        .ovw      (ovw),
        .iram_bad (iram_bad),
        .cfg_next (cfg_next)
    );

    // Nibble-presence flags for the merging write.
    for (genvar n = 0; n < NIB_N; n++) begin : g_nib
        assign nz_nib[n] = |acc_wdata[4*n +: 4];
    end

    // Memory port drive.
    assign dram_req   = routed && (kind == K_DRAM || kind == K_CELL);
    assign dram_we    = dram_req && acc_write;
    assign dram_addr  = cfg_use[CFG_W-1:WORD_W];
    assign dram_wdata = acc_wdata;
    assign dram_nmask = ovw ? nz_nib : {NIB_N{1'b1}};
    assign iram_we    = routed && acc_write && kind == K_IRAM;
    assign iram_addr  = cfg_use[WORD_W +: IRAM_AW];
    assign iram_wdata = acc_wdata;
    assign rom_req    = routed && !acc_write && kind == K_ROM;
    assign rom_addr   = {cfg_use[ROM_PW-1:0], cfg_use[CFG_W-1:WORD_W]};

    assign err_d = routed && (kind == K_BAD || (kind == K_IRAM && iram_bad));

    // Read return and error pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_err    <= 1'b0;
            rsrc_q     <= RS_REG;
            rdata_q    <= '0;
        end else begin
            acc_rvalid <= acc_valid && !acc_write;
            acc_err    <= err_d;
            if (acc_valid && !acc_write) begin
                rsrc_q  <= rom_req ? RS_ROM : (dram_req ? RS_DRAM : RS_REG);
                rdata_q <= prog_acc  ? prog_word[CFG_W-1:WORD_W] :
                           hold_path ? hold_q : '0;
            end
        end
    end

    // Read data select.
    always_comb begin
        case (rsrc_q)
            RS_DRAM: acc_rdata = dram_rdata;
            RS_ROM:  acc_rdata = rom_rdata;
            default: acc_rdata = rdata_q;
        endcase
    end
endmodule

// File: rtl/pmx_port_chk.sv
// Module pmx_port_chk
// Purpose : cycle-level protocol properties of pmx_port, bound to every instance.
// Assumes : synchronous active-low reset.
module pmx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_prog,
    input logic acc_write,
    input logic acc_rvalid,
    input logic acc_err,
    input logic dram_req,
    input logic dram_we,
    input logic iram_we,
    input logic rom_req,
    input logic armed
);
    p_rvalid_on_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> acc_rvalid);
    p_no_rvalid_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !acc_rvalid);
    p_bind_no_traffic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_prog && armed |-> !dram_req && !iram_we && !rom_req);
    p_bind_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_prog && armed |=> !armed);
    p_prog_no_traffic_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_prog |-> !dram_req && !iram_we && !rom_req);
    p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_req, iram_we, rom_req}));
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !dram_req && !iram_we && !rom_req);
    p_dram_we_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dram_we |-> dram_req && acc_write);
    p_iram_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iram_we |-> acc_valid && acc_write);
    p_rom_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> acc_valid && !acc_write);
    p_err_after_chan_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_prog) |=> !acc_err);
endmodule

bind pmx_port pmx_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_prog   (acc_prog),
    .acc_write  (acc_write),
    .acc_rvalid (acc_rvalid),
    .acc_err    (acc_err),
    .dram_req   (dram_req),
    .dram_we    (dram_we),
    .iram_we    (iram_we),
    .rom_req    (rom_req),
    .armed      (armed)
);

// File: tb/pmx_port_tb.sv
// Bench for pmx_port: directed corner cases plus seeded random traffic, compared
// against a reference model held in bench tasks.
module pmx_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_prog = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_chan = '0;
    logic [15:0] acc_wdata = '0;
    logic [1:0]  mem_route = '0;
    logic        acc_rvalid, acc_err;
    logic [15:0] acc_rdata;
    logic        dram_req, dram_we, iram_we, rom_req;
    logic [15:0] dram_addr, dram_wdata, iram_wdata;
    logic [3:0]  dram_nmask;
    logic [9:0]  iram_addr;
    logic [19:0] rom_addr;
    logic [15:0] dram_q = '0, rom_q = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmx_port dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_prog(acc_prog),
        .acc_write(acc_write), .acc_chan(acc_chan), .acc_wdata(acc_wdata),
        .mem_route(mem_route), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .dram_req(dram_req), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_nmask(dram_nmask),
        .dram_rdata(dram_q), .iram_we(iram_we), .iram_addr(iram_addr),
        .iram_wdata(iram_wdata), .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_rdata(rom_q)
    );

    // Memory models (bench side) and traffic counter.
    logic [15:0] dram_mem [1024];
    logic [15:0] iram_mem [1024];
    int          traffic = 0;

    function automatic logic [15:0] rom_fn(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3} ^ 16'h0F0F;
    endfunction

    always @(posedge clk) begin
        if (dram_req) begin
            if (dram_we) begin
                logic [15:0] v;
                v = dram_mem[dram_addr[9:0]];
                for (int k = 0; k < 4; k++)
                    if (dram_nmask[k]) v[4*k +: 4] = dram_wdata[4*k +: 4];
                dram_mem[dram_addr[9:0]] = v;
            end else begin
                dram_q <= dram_mem[dram_addr[9:0]];
            end
        end
        if (iram_we) iram_mem[iram_addr] = iram_wdata;
        if (rom_req) rom_q <= rom_fn(rom_addr);
        if (dram_req || iram_we || rom_req) traffic = traffic + 1;
    end

    // Reference model state.
    logic [15:0] m_hi = '0, m_lo = '0;
    logic        m_have = 1'b0, m_arm = 1'b0;
    logic [31:0] m_crd [5];
    logic [31:0] m_cwr [5];
    logic [15:0] m_hold [5];
    logic [15:0] ref_dram [1024];
    logic [15:0] ref_iram [1024];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step_of(input logic [15:0] mode);
        logic [15:0] v;
        case (mode[13:11])
            3'd0: v = 16'd0;   3'd1: v = 16'd1;  3'd2: v = 16'd2;  3'd3: v = 16'd4;
            3'd4: v = 16'd8;   3'd5: v = 16'd16; 3'd6: v = 16'd32; default: v = 16'd128;
        endcase
        return mode[15] ? (16'd0 - v) : v;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic ow);
        logic [15:0] r;
        r = old;
        for (int k = 0; k < 4; k++)
            if (!ow || d[4*k +: 4] != 4'h0) r[4*k +: 4] = d[4*k +: 4];
        return r;
    endfunction

    // Reference model of one access.
    task automatic m_acc(input logic prog, input logic wr, input logic [2:0] ch,
                         input logic [15:0] d, output logic [15:0] erd,
                         output logic eerr, output logic etr);
        logic [31:0] c;
        logic [15:0] mode, a;
        erd = '0; eerr = 1'b0; etr = 1'b0;
        if (prog) begin
            if (!wr) erd = m_hi;
            if (m_have) begin
                if (wr) m_lo = d;
                m_arm = 1'b1; m_have = 1'b0;
            end else begin
                if (wr) m_hi = d;
                m_have = 1'b1;
            end
        end else begin
            m_have = 1'b0;
            if (m_arm) begin
                if (wr) m_cwr[ch] = {m_hi, m_lo}; else m_crd[ch] = {m_hi, m_lo};
                m_arm = 1'b0;
            end else if (ch == 3'd4 || mem_route != 2'b00) begin
                c = wr ? m_cwr[ch] : m_crd[ch];
                mode = c[15:0]; a = c[31:16];
                if (wr) begin
                    if ((mode & 16'h43FF) == 16'h0018) begin
                        ref_dram[a[9:0]] = merge(ref_dram[a[9:0]], d, mode[10]);
                        a = a + step_of(mode); etr = 1'b1;
                    end else if ((mode & 16'hFBFF) == 16'h4018) begin
                        ref_dram[a[9:0]] = merge(ref_dram[a[9:0]], d, mode[10]);
                        a = a + (a[0] ? 16'd31 : 16'd1); etr = 1'b1;
                    end else if ((mode & 16'h47FF) == 16'h001C) begin
                        ref_iram[a[9:0]] = d;
                        eerr = (a[15:10] != 6'b100000);
                        a = a + step_of(mode); etr = 1'b1;
                    end else eerr = 1'b1;
                    c = {a, mode};
                    m_cwr[ch] = c;
                end else begin
                    if ((mode & 16'hFFF0) == 16'h0800) begin
                        erd = rom_fn({mode[3:0], a});
                        c = c + 32'h0001_0000 + {31'd0, a == 16'hFFFF}; etr = 1'b1;
                    end else if ((mode & 16'h47FF) == 16'h0018) begin
                        erd = ref_dram[a[9:0]];
                        c = {a + step_of(mode), mode}; etr = 1'b1;
                    end else eerr = 1'b1;
                    m_crd[ch] = c;
                end
                {m_hi, m_lo} = c;
            end else begin
                if (wr) m_hold[ch] = d; else erd = m_hold[ch];
            end
        end
    endtask

    // One access on the DUT, checked against the model.
    task automatic run(input logic prog, input logic wr, input logic [2:0] ch,
                       input logic [15:0] d, input string tag, output logic [15:0] got);
        logic [15:0] erd; logic eerr, etr; int t0;
        @(negedge clk);
        acc_valid = 1'b1; acc_prog = prog; acc_write = wr; acc_chan = ch; acc_wdata = d;
        t0 = traffic;
        m_acc(prog, wr, ch, d, erd, eerr, etr);
        @(negedge clk);
        acc_valid = 1'b0;
        got = acc_rdata;
        chk({tag, " R13 rvalid"}, 32'(acc_rvalid), 32'(!wr));
        if (!wr) chk({tag, " rdata"}, 32'(acc_rdata), 32'(erd));
        chk({tag, " R12 err"}, 32'(acc_err), 32'(eerr));
        chk({tag, " R3 traffic"}, 32'(traffic - t0), 32'(etr));
    endtask

    // Stage and bind a descriptor to a channel slot.
    task automatic cfg(input logic [2:0] ch, input logic wr, input logic [15:0] a,
                       input logic [15:0] mode);
        logic [15:0] g; logic [1:0] sv;
        if (m_have) begin
            sv = mem_route; mem_route = 2'b00;
            run(1'b0, 1'b0, 3'd0, 16'h0, "R2 clear phase", g);
            mem_route = sv;
        end
        run(1'b1, 1'b1, 3'd0, a, "R1 stage address", g);
        run(1'b1, 1'b1, 3'd0, mode, "R1 stage mode", g);
        run(1'b0, wr, ch, 16'h0, "R2 bind", g);
    endtask

    initial begin
        logic [15:0] g;
        int mism;
        for (int i = 0; i < 1024; i++) begin
            dram_mem[i] = '0; ref_dram[i] = '0; iram_mem[i] = '0; ref_iram[i] = '0;
        end
        for (int i = 0; i < 5; i++) begin m_crd[i] = '0; m_cwr[i] = '0; m_hold[i] = '0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R13 reset rvalid", 32'(acc_rvalid), 32'd0);
        chk("R12 reset err", 32'(acc_err), 32'd0);
        rst_n = 1'b1;
        run(1'b1, 1'b0, 3'd0, 16'h0, "R1 reset read", g);
        chk("R1 reset staging", 32'(g), 32'h0);
        run(1'b0, 1'b0, 3'd0, 16'h0, "R3 reset hold", g);

        // R1/R4/R5/R11: linear DRAM writes with step 4, then staging reload.
        run(1'b1, 1'b1, 3'd0, 16'h0010, "R1 addr", g);
        run(1'b1, 1'b1, 3'd0, 16'h1818, "R1 mode", g);
        run(1'b1, 1'b0, 3'd0, 16'h0, "R1 read staged", g);
        chk("R1 read returns address half", 32'(g), 32'h0010);
        run(1'b0, 1'b1, 3'd4, 16'h0, "R2 bind write slot", g);
        run(1'b0, 1'b1, 3'd4, 16'hAAAA, "R5 write", g);
        run(1'b0, 1'b1, 3'd4, 16'h5555, "R5 write", g);
        chk("R5 dram[0x10]", 32'(dram_mem[16]), 32'hAAAA);
        chk("R4 step 4 dram[0x14]", 32'(dram_mem[20]), 32'h5555);
        run(1'b1, 1'b0, 3'd0, 16'h0, "R11 reload", g);
        chk("R11 staging holds stepped address", 32'(g), 32'h0018);

        // R6/R4: DRAM read with negative step 2.
        cfg(3'd4, 1'b0, 16'h0014, 16'h9018);
        run(1'b0, 1'b0, 3'd4, 16'h0, "R6 read", g);
        chk("R6 dram read", 32'(g), 32'h5555);
        run(1'b0, 1'b0, 3'd4, 16'h0, "R6 read", g);
        run(1'b1, 1'b0, 3'd0, 16'h0, "R4 negative step", g);
        chk("R4 address after two -2 steps", 32'(g), 32'h0010);

        // R4: step code 7 gives 128.
        cfg(3'd4, 1'b1, 16'h0100, 16'h3818);
        run(1'b0, 1'b1, 3'd4, 16'h1111, "R4 step128", g);
        run(1'b0, 1'b1, 3'd4, 16'h2222, "R4 step128", g);
        chk("R4 step 128 lands at 0x180", 32'(dram_mem[16'h180]), 32'h2222);

        // R7: nibble-merging write.
        cfg(3'd4, 1'b1, 16'h0030, 16'h0418);
        run(1'b0, 1'b1, 3'd4, 16'hFFFF, "R7 ovw", g);
        run(1'b0, 1'b1, 3'd4, 16'h0A0B, "R7 ovw", g);
        chk("R7 zero nibbles kept", 32'(dram_mem[16'h30]), 32'hFAFB);
        run(1'b0, 1'b1, 3'd4, 16'h0000, "R7 ovw zero", g);
        chk("R7 all-zero data changes nothing", 32'(dram_mem[16'h30]), 32'hFAFB);

        // R8: cell stepping.
        cfg(3'd4, 1'b1, 16'h0021, 16'h4018);
        run(1'b0, 1'b1, 3'd4, 16'h0001, "R8 cell", g);
        run(1'b0, 1'b1, 3'd4, 16'h0002, "R8 cell", g);
        run(1'b0, 1'b1, 3'd4, 16'h0003, "R8 cell", g);
        chk("R8 odd +31", 32'(dram_mem[16'h40]), 32'h0002);
        chk("R8 even +1", 32'(dram_mem[16'h41]), 32'h0003);

        // R9: instruction RAM writes, valid and invalid address.
        cfg(3'd4, 1'b1, 16'h8005, 16'h081C);
        run(1'b0, 1'b1, 3'd4, 16'h7777, "R9 iram", g);
        run(1'b0, 1'b1, 3'd4, 16'h8888, "R9 iram", g);
        chk("R9 iram[5]", 32'(iram_mem[5]), 32'h7777);
        chk("R9 iram[6]", 32'(iram_mem[6]), 32'h8888);
        cfg(3'd4, 1'b1, 16'h1009, 16'h001C);
        run(1'b0, 1'b1, 3'd4, 16'h9999, "R9 bad iram addr", g);
        chk("R9 bad address still writes", 32'(iram_mem[9]), 32'h9999);

        // R10: ROM page carry.
        cfg(3'd4, 1'b0, 16'hFFFF, 16'h0803);
        run(1'b0, 1'b0, 3'd4, 16'h0, "R10 rom", g);
        chk("R10 rom word 3FFFF", 32'(g), 32'(rom_fn(20'h3FFFF)));
        run(1'b0, 1'b0, 3'd4, 16'h0, "R10 rom", g);
        chk("R10 rom carries to page 4", 32'(g), 32'(rom_fn(20'h40000)));

        // R12: unrecognized read and write modes.
        cfg(3'd4, 1'b0, 16'h0000, 16'h0019);
        run(1'b0, 1'b0, 3'd4, 16'h0, "R12 bad read", g);
        chk("R12 bad read returns zero", 32'(g), 32'h0);
        cfg(3'd4, 1'b1, 16'h0002, 16'h0800);
        run(1'b0, 1'b1, 3'd4, 16'hDEAD, "R12 bad write", g);
        chk("R12 bad write ignored", 32'(dram_mem[2]), 32'h0);

        // R3: routing versus holding register.
        mem_route = 2'b01;
        cfg(3'd2, 1'b1, 16'h0200, 16'h0818);
        run(1'b0, 1'b1, 3'd2, 16'h4242, "R3 routed ch2", g);
        chk("R3 routed write reaches DRAM", 32'(dram_mem[16'h200]), 32'h4242);
        mem_route = 2'b00;
        run(1'b0, 1'b1, 3'd2, 16'hBEEF, "R3 hold write", g);
        run(1'b0, 1'b0, 3'd2, 16'h0, "R3 hold read", g);
        chk("R3 hold readback", 32'(g), 32'hBEEF);
        chk("R3 hold write skips DRAM", 32'(dram_mem[16'h201]), 32'h0);

        // Random traffic against the model.
        for (int it = 0; it < 400; it++) begin
            logic [2:0] ch; logic wr; logic [15:0] md, ad; int pick;
            mem_route = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom);
            ch = 3'($urandom % 5);
            wr = 1'($urandom);
            pick = $urandom % 4;
            if (pick == 0) begin
                ad = 16'($urandom);
                case ($urandom % 6)
                    0: md = {1'($urandom), 1'b0, 3'($urandom), 1'($urandom), 10'h018};
                    1: md = {5'b01000, 1'($urandom), 10'h018};
                    2: md = {12'h080, 4'($urandom % 15)};
                    3: md = {1'($urandom), 1'b0, 3'($urandom), 1'b0, 10'h018};
                    4: md = {1'($urandom), 1'b0, 3'($urandom), 1'b0, 10'h01C};
                    default: md = 16'($urandom);
                endcase
                cfg(ch, wr, ad, md);
            end else if (pick == 1) begin
                run(1'b1, 1'b0, 3'd0, 16'h0, "R11 random staging read", g);
            end else begin
                run(1'b0, wr, ch, 16'($urandom), "R5 random access", g);
            end
        end

        mism = 0;
        for (int i = 0; i < 1024; i++) begin
            if (dram_mem[i] !== ref_dram[i]) mism++;
            if (iram_mem[i] !== ref_iram[i]) mism++;
        end
        chk("R7 memory contents match model", 32'(mism), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule